// File: doc/BRIEF.md
# Circuit Breaker Fault Timer

This block is the digital form of the single timing capacitor in a hot-swap controller. One saturating up/down counter does two jobs. It first times a start-up delay before the pass-switch gate is enabled. While the gate is on, it integrates overcurrent time. The count rises quickly while overcurrent is flagged and falls slowly once the overcurrent clears. If the count reaches the threshold, a latched breaker trip follows.

All analog sensing appears here as digital flags: undervoltage, overvoltage, supply lockout, soft-start level, overcurrent and high drain voltage. A free-running prescaler sets the slow tick. Every count happens on a tick, so rates are expressed as counts per tick. The trip holds the gate off, sets the fault flag and drives power-good-one inactive. It stays latched until one of four clear paths is taken.

Top module: `breaker_timer`

## Requirements
- R1: After reset, `gate_en`=0, `fault`=0, `pg1_n`=1 and `tmr_val`=0.
- R2: No start-up cycle begins while any inhibit is present (`clr_req`, `uv_fault`, `ov_fault`, `lkout`, `ss_high` or `oc` high). `tmr_val` stays 0 and `gate_en` stays 0.
- R3: With all inhibits low and the timer at zero, a start-up cycle counts up by 1 per tick. When the count would reach `THRESH`, the counter returns to 0 and `gate_en` goes to 1.
- R4: `pg1_n` goes low one clock after `gate_en` rises. `pg1_n` is high in every cycle in which `gate_en` is 0.
- R5: While the gate is on and `oc`=1, the count rises by `FAST_STEP` (default 40) per tick.
- R6: While the gate is on and both `oc` and `drain_hi` are 1, the count rises by `FAST_STEP`+`DRAIN_STEP` (default 48) per tick.
- R7: While the gate is on and `oc`=0, the count falls by 1 per tick down to 0.
- R8: When the breaker count reaches `THRESH`, the breaker trips. `gate_en` goes to 0, `fault` goes to 1, `pg1_n` goes to 1 and `tmr_val` latches at `THRESH`. These hold after `oc` falls.
- R9: While tripped, holding `clr_req` high counts the timer down by 1 per tick. The fault clears when the count reaches 0.
- R10: `uv_fault` high for one clock clears a trip. In any state it leaves `tmr_val`=0 and `gate_en`=0 on the next clock.
- R11: `lkout` high for one clock clears a trip. In any state it leaves `tmr_val`=0 and `gate_en`=0 on the next clock.
- R12: `ext_zero` high for one clock forces `tmr_val` to 0 and clears a trip.
- R13: The counter saturates. `tmr_val` never exceeds `THRESH` and never wraps below 0. With `THRESH`=210, the sixth 40-count step stops at 210.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_req | input | 1 | Reset request; counts a tripped timer down, inhibits start |
| uv_fault | input | 1 | Undervoltage present |
| ov_fault | input | 1 | Overvoltage present |
| lkout | input | 1 | Supply below lockout threshold |
| ss_high | input | 1 | Soft-start node not yet low |
| oc | input | 1 | Overcurrent flag |
| drain_hi | input | 1 | High drain voltage flag |
| ext_zero | input | 1 | External pull of the timer to zero |
| gate_en | output | 1 | Pass-switch gate enable |
| fault | output | 1 | Latched breaker fault |
| pg1_n | output | 1 | Power-good-one, active low |
| tmr_val | output | CNT_W | Timer count |

## Verification
The assertions check on every cycle the bounds and relations that must always hold. The count stays within 0..`THRESH`. The gate and the fault are never high together. `pg1_n` follows the gate with its one-clock lag. No single step exceeds the drain-boosted rate. A trip always shows the count at the threshold. An undervoltage or lockout pulse always leaves the gate off and the count at zero. Only the bench scenarios can show the exact step sizes of 1, 40 and 48, the ordering of the start-up delay, the latch surviving removal of overcurrent, and each distinct clear path.

// File: rtl/breaker_timer.sv
module breaker_timer #(
  parameter int CNT_W      = 12,
  parameter int THRESH     = 210,
  parameter int TICK_DIV   = 4,
  parameter int FAST_STEP  = 40,
  parameter int DRAIN_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_req,
  input  logic             uv_fault,
  input  logic             ov_fault,
  input  logic             lkout,
  input  logic             ss_high,
  input  logic             oc,
  input  logic             drain_hi,
  input  logic             ext_zero,
  output logic             gate_en,
  output logic             fault,
  output logic             pg1_n,
  output logic [CNT_W-1:0] tmr_val
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(THRESH);
  localparam logic [CNT_W:0] BIG  = (CNT_W+1)'(FAST_STEP + DRAIN_STEP);
  localparam logic [CNT_W:0] FAST = (CNT_W+1)'(FAST_STEP);

  typedef enum logic [1:0] {S_IDLE, S_START, S_ON, S_TRIP} st_t;

  st_t              st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [DIV_W-1:0] div;
  logic             pg_q;
  logic             tick, abort;
  logic [CNT_W:0]   step, sum;

  assign tick  = (div == DIV_W'(TICK_DIV - 1));
  assign abort = clr_req | uv_fault | ov_fault | lkout;
  assign step  = (st == S_ON && oc) ? (drain_hi ? BIG : FAST) : (CNT_W+1)'(1);
  assign sum   = {1'b0, cnt} + step;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_IDLE:
        if (!abort && !ss_high && !oc && cnt == '0) st_n = S_START;
      S_START:
        if (abort) begin
          st_n  = S_IDLE;
          cnt_n = '0;
        end else if (tick) begin
          if (sum >= {1'b0, TOP}) begin
            st_n  = S_ON;
            cnt_n = '0;
          end else cnt_n = sum[CNT_W-1:0];
        end
      S_ON:
        if (abort) begin
          st_n  = S_IDLE;
          cnt_n = '0;
        end else if (tick) begin
          if (oc) begin
            if (sum >= {1'b0, TOP}) begin
              st_n  = S_TRIP;
              cnt_n = TOP;
            end else cnt_n = sum[CNT_W-1:0];
          end else if (cnt != '0) cnt_n = cnt - 1'b1;
        end
      S_TRIP:
        if (uv_fault || lkout || ext_zero) begin
          st_n  = S_IDLE;
          cnt_n = '0;
        end else if (clr_req && tick) begin
          if (cnt <= CNT_W'(1)) begin
            st_n  = S_IDLE;
            cnt_n = '0;
          end else cnt_n = cnt - 1'b1;
        end
      default: begin
        st_n  = S_IDLE;
        cnt_n = '0;
      end
    endcase
    if (ext_zero) cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      div  <= '0;
      pg_q <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      div  <= tick ? '0 : div + 1'b1;
      pg_q <= (st == S_ON);
    end
  end

  assign gate_en = (st == S_ON);
  assign fault   = (st == S_TRIP);
  assign pg1_n   = !(gate_en && pg_q);
  assign tmr_val = cnt;
endmodule

module breaker_timer_chk #(
  parameter int CNT_W      = 12,
  parameter int THRESH     = 210,
  parameter int FAST_STEP  = 40,
  parameter int DRAIN_STEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uv_fault,
  input logic             lkout,
  input logic             gate_en,
  input logic             fault,
  input logic             pg1_n,
  input logic [CNT_W-1:0] tmr_val
);
  p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tmr_val) <= THRESH);
  p_gate_fault_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && fault));
  p_trip_at_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> int'(tmr_val) == THRESH);
  p_pg_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> pg1_n);
  p_pg_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |=> (gate_en ? !pg1_n : pg1_n));
  p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_val > $past(tmr_val)) |-> (int'(tmr_val) - int'($past(tmr_val)) <= FAST_STEP + DRAIN_STEP));
  p_uv_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> (!gate_en && !fault && tmr_val == '0));
  p_lk_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lkout |=> (!gate_en && !fault && tmr_val == '0));
endmodule

bind breaker_timer breaker_timer_chk #(
  .CNT_W(CNT_W), .THRESH(THRESH), .FAST_STEP(FAST_STEP), .DRAIN_STEP(DRAIN_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_fault(uv_fault), .lkout(lkout),
  .gate_en(gate_en), .fault(fault), .pg1_n(pg1_n), .tmr_val(tmr_val)
);

// File: tb/breaker_timer_tb.sv
module breaker_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int THRESH = 210;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_req = 1'b0, uv_fault = 1'b0, ov_fault = 1'b0, lkout = 1'b0;
  logic ss_high = 1'b1, oc = 1'b0, drain_hi = 1'b0, ext_zero = 1'b0;
  logic gate_en, fault, pg1_n;
  logic [CNT_W-1:0] tmr_val;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  breaker_timer #(.CNT_W(CNT_W), .THRESH(THRESH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .uv_fault(uv_fault),
    .ov_fault(ov_fault), .lkout(lkout), .ss_high(ss_high), .oc(oc),
    .drain_hi(drain_hi), .ext_zero(ext_zero), .gate_en(gate_en),
    .fault(fault), .pg1_n(pg1_n), .tmr_val(tmr_val)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_change(input int lim);
    logic [CNT_W-1:0] old;
    old = tmr_val;
    for (int i = 0; i < lim && tmr_val == old; i++) @(negedge clk);
  endtask

  task automatic wait_gate(input int lim);
    for (int i = 0; i < lim && !gate_en; i++) @(negedge clk);
  endtask

  task automatic wait_fault(input logic lvl, input int lim);
    for (int i = 0; i < lim && fault != lvl; i++) @(negedge clk);
  endtask

  task automatic bring_up(input string req);
    ss_high = 1'b0;
    wait_gate(4000);
    chk({req, " gate on"}, gate_en, 1);
  endtask

  task automatic t_reset;
    chk("R1 gate", gate_en, 0);
    chk("R1 fault", fault, 0);
    chk("R1 pg1_n", pg1_n, 1);
    chk("R1 tmr", tmr_val, 0);
  endtask

  task automatic t_inhibit;
    step_n(50);
    chk("R2 ss_high holds tmr", tmr_val, 0);
    chk("R2 ss_high holds gate", gate_en, 0);
    ss_high = 1'b0; oc = 1'b1;
    step_n(50);
    chk("R2 oc holds tmr", tmr_val, 0);
    oc = 1'b0; ov_fault = 1'b1;
    step_n(50);
    chk("R2 ov holds tmr", tmr_val, 0);
    ov_fault = 1'b0; ss_high = 1'b1;
  endtask

  task automatic t_start;
    ss_high = 1'b0;
    wait_change(20);
    chk("R3 first start step", tmr_val, 1);
    wait_change(20);
    chk("R3 second start step", tmr_val, 2);
    chk("R3 gate off during delay", gate_en, 0);
    wait_gate(4000);
    chk("R3 gate on at end", gate_en, 1);
    chk("R3 tmr zero at end", tmr_val, 0);
    chk("R4 pg1_n still high", pg1_n, 1);
    step_n(1);
    chk("R4 pg1_n low next clock", pg1_n, 0);
  endtask

  task automatic t_fast_and_decay;
    oc = 1'b1;
    wait_change(20);
    chk("R5 fast step", tmr_val, 40);
    oc = 1'b0;
    wait_change(20);
    chk("R7 slow decay", tmr_val, 39);
    wait_change(20);
    chk("R7 slow decay again", tmr_val, 38);
    for (int i = 0; i < 400 && tmr_val != 0; i++) @(negedge clk);
    step_n(20);
    chk("R13 floor at zero", tmr_val, 0);
    chk("R7 gate still on", gate_en, 1);
  endtask

  task automatic t_drain;
    oc = 1'b1; drain_hi = 1'b1;
    wait_change(20);
    chk("R6 drain boosted step", tmr_val, 48);
    oc = 1'b0; drain_hi = 1'b0;
    for (int i = 0; i < 400 && tmr_val != 0; i++) @(negedge clk);
  endtask

  task automatic t_trip;
    oc = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      wait_change(20);
      chk("R5 accumulate", tmr_val, 40 * k);
    end
    wait_fault(1'b1, 20);
    chk("R13 saturated at threshold", tmr_val, THRESH);
    chk("R8 fault", fault, 1);
    chk("R8 gate off", gate_en, 0);
    chk("R8 pg1_n high", pg1_n, 1);
    oc = 1'b0;
    step_n(60);
    chk("R8 latched fault", fault, 1);
    chk("R8 latched tmr", tmr_val, THRESH);
  endtask

  task automatic t_clr_req;
    clr_req = 1'b1;
    wait_change(20);
    chk("R9 count down", tmr_val, THRESH - 1);
    chk("R9 still faulted", fault, 1);
    wait_fault(1'b0, 2000);
    chk("R9 fault cleared", fault, 0);
    chk("R9 tmr zero", tmr_val, 0);
    step_n(20);
    chk("R2 clr_req holds gate", gate_en, 0);
    clr_req = 1'b0;
  endtask

  task automatic trip_again(input string req);
    bring_up(req);
    oc = 1'b1;
    wait_fault(1'b1, 200);
    oc = 1'b0;
    chk({req, " tripped"}, fault, 1);
    ss_high = 1'b1;
  endtask

  task automatic t_uv;
    trip_again("R10");
    uv_fault = 1'b1;
    step_n(1);
    uv_fault = 1'b0;
    chk("R10 fault cleared", fault, 0);
    chk("R10 tmr zero", tmr_val, 0);
  endtask

  task automatic t_lk;
    trip_again("R11");
    lkout = 1'b1;
    step_n(1);
    lkout = 1'b0;
    chk("R11 fault cleared", fault, 0);
    chk("R11 tmr zero", tmr_val, 0);
    bring_up("R11");
    lkout = 1'b1;
    step_n(1);
    lkout = 1'b0; ss_high = 1'b1;
    chk("R11 gate off from on", gate_en, 0);
  endtask

  task automatic t_ext;
    trip_again("R12");
    ext_zero = 1'b1;
    step_n(1);
    ext_zero = 1'b0;
    chk("R12 fault cleared", fault, 0);
    chk("R12 tmr zero", tmr_val, 0);
  endtask

  initial begin
    step_n(3);
    rst_n = 1'b1;
    step_n(1);
    t_reset();
    t_inhibit();
    t_start();
    t_fast_and_decay();
    t_drain();
    t_trip();
    t_clr_req();
    t_uv();
    t_lk();
    t_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule